// File: doc/BRIEF.md
# Horizontal Display Window Comparator

This block decides, one beam position at a time, whether the current horizontal position lies inside the visible display window. It keeps three small registers that a write port updates: an opening register, a closing register and a shared extension register. The low byte of the opening register gives the position where the window opens. The low byte of the closing register gives the position where it shuts. In the extended chipset mode, the extension register adds a ninth position bit to each of them. The registered window flag sets when the beam counter reaches a valid opening position and clears when it reaches a valid closing position.

A mode input selects legacy or extended behaviour. In legacy mode the extension register is frozen and the ninth bit of both positions reads as zero. Some positions can be computed but are never reached or are reserved. These positions never open or close the window. A write is compared against the counter in the same cycle that it arrives, so software can move the window edges in the middle of a line, and as often as it likes within a frame.

Top module: `hwin_comparator`

## Requirements
- R1: While `rst` is high, and on the first clock edge where it is high, `win_en` goes to 0 and all three registers clear. After reset, with no writes, `win_en` stays 0 for every counter value.
- R2: In extended mode (`ext_mode`=1), the opening position is {extension bit 5, opening register bits 7:0}.
- R3: In extended mode, the closing position is {extension bit 13, closing register bits 7:0}.
- R4: A computed opening or closing position above 0x1C7 never changes `win_en`.
- R5: A computed opening or closing position of 0 or 1 never changes `win_en`.
- R6: When `ext_mode`=0, writes to the extension register are discarded, so its contents are unchanged on a later switch to extended mode. In this mode, bit 8 of both positions is 0.
- R7: Write port addresses are 0 for the opening register, 1 for the closing register, 2 for the extension register, and 3 for no register. A write is used in the comparison of the same clock edge at which it is captured.
- R8: `win_en` sets on an edge where `hpos` equals a valid opening position. It clears on an edge where `hpos` equals a valid closing position. If both match, clearing wins. Otherwise it holds.
- R9: `win_en` is a flop output. It changes only at the clock edge that follows the cycle in which the match was presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1 selects extended chipset behaviour, 0 selects legacy |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 opening, 1 closing, 2 extension, 3 none) |
| wr_data | input | 16 | Write data word |
| hpos | input | 9 | Beam horizontal counter |
| win_en | output | 1 | Registered horizontal window enable |

## Verification
The bench builds the block with its default 9-bit position and 16-bit data word. With these values, a full sweep of all 512 counter values takes only a few hundred cycles. Each configuration is therefore swept over every counter value, and that includes the unreachable range above 0x1C7 and the reserved values 0 and 1. The sweeps cover both modes, and the ninth bit is both clear and set. Single-cycle writes on the counter value that matches the write make the same-edge bypass and the equal-position priority visible directly at the output.

// File: rtl/hwin_pkg.sv
package hwin_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_OPEN  = 2'd0,
    SEL_CLOSE = 2'd1,
    SEL_EXT   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int EDGE_N = 2;
  localparam int EDGE_OPEN = 0;
  localparam int EDGE_CLOSE = 1;
endpackage

// File: rtl/hwin_regs.sv
module hwin_regs
  import hwin_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_mode,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] open_nx,
  output logic [DATA_W-1:0] close_nx,
  output logic [DATA_W-1:0] ext_nx
);
  logic [DATA_W-1:0] open_q, close_q, ext_q;
  logic hit_open, hit_close, hit_ext;

  always_comb begin
    hit_open  = wr_en && (reg_sel_e'(wr_addr) == SEL_OPEN);
    hit_close = wr_en && (reg_sel_e'(wr_addr) == SEL_CLOSE);
    hit_ext   = wr_en && (reg_sel_e'(wr_addr) == SEL_EXT) && ext_mode;
  end

  // Bypass: values seen by the comparators in the cycle of the write
  always_comb begin
    open_nx  = hit_open  ? wr_data : open_q;
    close_nx = hit_close ? wr_data : close_q;
    ext_nx   = hit_ext   ? wr_data : ext_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= '0;
      close_q <= '0;
      ext_q   <= '0;
    end else begin
      open_q  <= open_nx;
      close_q <= close_nx;
      ext_q   <= ext_nx;
    end
  end

  assert_ext_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    !ext_mode |=> $stable(ext_q));

  assert_open_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0) |=> open_q == $past(wr_data));

  assert_close_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd1) |=> close_q == $past(wr_data));
endmodule

// File: rtl/hwin_edge.sv
module hwin_edge #(
  parameter int POS_W     = 9,
  parameter int FIRST_POS = 2,
  parameter int LAST_POS  = 'h1C7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_mode,
  input  logic [POS_W-2:0]   low_part,
  input  logic               high_bit,
  input  logic [POS_W-1:0]   hpos,
  output logic               hit
);
  localparam int LOW_W = POS_W - 1;
  localparam logic [POS_W-1:0] FIRST_V = POS_W'(FIRST_POS);
  localparam logic [POS_W-1:0] LAST_V  = POS_W'(LAST_POS);

  logic [POS_W-1:0] pos;
  logic             legal;

  always_comb begin
    pos = '0;
    pos[LOW_W-1:0] = low_part;
    pos[LOW_W]     = ext_mode & high_bit;
    legal = (pos >= FIRST_V) && (pos <= LAST_V);
    hit   = legal && (hpos == pos);
  end

  assert_hit_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    hit |-> hpos <= LAST_V);

  assert_hit_not_reserved_R5: assert property (@(posedge clk) disable iff (rst)
    hit |-> hpos >= FIRST_V);

  assert_legacy_low_half_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && !ext_mode) |-> !hpos[POS_W-1]);
endmodule

// File: rtl/hwin_flag.sv
module hwin_flag (
  input  logic clk,
  input  logic rst,
  input  logic open_hit,
  input  logic close_hit,
  output logic win_en
);
  always_ff @(posedge clk) begin
    if (rst)            win_en <= 1'b0;
    else if (close_hit) win_en <= 1'b0;
    else if (open_hit)  win_en <= 1'b1;
  end

  assert_close_wins_R8: assert property (@(posedge clk) disable iff (rst)
    close_hit |=> !win_en);

  assert_open_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (open_hit && !close_hit) |=> win_en);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!open_hit && !close_hit) |=> $stable(win_en));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> !win_en);
endmodule

// File: rtl/hwin_comparator.sv
module hwin_comparator
  import hwin_pkg::*;
#(
  parameter int POS_W        = 9,
  parameter int DATA_W       = 16,
  parameter int FIRST_POS    = 2,
  parameter int LAST_POS     = 'h1C7,
  parameter int OPEN_HI_BIT  = 5,
  parameter int CLOSE_HI_BIT = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_mode,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [POS_W-1:0]  hpos,
  output logic              win_en
);
  localparam int LOW_W = POS_W - 1;
  localparam logic [DATA_W-1:0] HI_MASK =
    (DATA_W'(1) << OPEN_HI_BIT) | (DATA_W'(1) << CLOSE_HI_BIT);

  logic [DATA_W-1:0] open_w, close_w, ext_w;
  logic [LOW_W-1:0]  low_arr [EDGE_N];
  logic              hi_arr  [EDGE_N];
  logic              hit_arr [EDGE_N];
  logic              unused_bits;

  hwin_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .ext_mode(ext_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .open_nx(open_w), .close_nx(close_w), .ext_nx(ext_w)
  );

  assign low_arr[EDGE_OPEN]  = open_w[LOW_W-1:0];
  assign low_arr[EDGE_CLOSE] = close_w[LOW_W-1:0];
  assign hi_arr[EDGE_OPEN]   = ext_w[OPEN_HI_BIT];
  assign hi_arr[EDGE_CLOSE]  = ext_w[CLOSE_HI_BIT];
  assign unused_bits = ^{open_w[DATA_W-1:LOW_W], close_w[DATA_W-1:LOW_W],
                         ext_w & ~HI_MASK};

  for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
    hwin_edge #(
      .POS_W(POS_W), .FIRST_POS(FIRST_POS), .LAST_POS(LAST_POS)
    ) u_edge (
      .clk(clk), .rst(rst), .ext_mode(ext_mode),
      .low_part(low_arr[g]), .high_bit(hi_arr[g]),
      .hpos(hpos), .hit(hit_arr[g])
    );
  end

  hwin_flag u_flag (
    .clk(clk), .rst(rst),
    .open_hit(hit_arr[EDGE_OPEN]), .close_hit(hit_arr[EDGE_CLOSE]),
    .win_en(win_en)
  );

  assert_same_edge_open_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0 && wr_data[LOW_W-1:0] == hpos[LOW_W-1:0]
     && !hpos[LOW_W] && hpos >= POS_W'(FIRST_POS)
     && !hit_arr[EDGE_CLOSE]) |=> win_en);

  assert_ext_open_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (ext_mode && hit_arr[EDGE_OPEN]) |-> hpos[LOW_W] == ext_w[OPEN_HI_BIT]);

  assert_ext_close_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (ext_mode && hit_arr[EDGE_CLOSE]) |-> hpos[LOW_W] == ext_w[CLOSE_HI_BIT]);
endmodule

// File: tb/hwin_comparator_bench.sv
module hwin_comparator_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd3;
  logic [15:0] wr_data = '0;
  logic [8:0]  hpos = '0;
  logic        win_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] m_open = '0, m_close = '0, m_ext = '0;
  logic        m_en = 1'b0;

  always #2 clk = ~clk;

  hwin_comparator u_hwin_comparator (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .hpos(hpos), .win_en(win_en)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: win_en=%0b expected %0b (hpos=%0h)", tag, got, exp, hpos);
    end
  endtask

  function automatic bit fires(input logic [8:0] pos, input logic [8:0] p);
    return (p == pos) && (pos >= 9'd2) && (pos <= 9'h1C7);
  endfunction

  // Called at a falling edge; presents one cycle and checks both sides of the edge
  task automatic tick(input logic we, input logic [1:0] a, input logic [15:0] d,
                      input logic m, input logic [8:0] p, input string tag);
    logic [8:0] so, sc;
    wr_en = we; wr_addr = a; wr_data = d; ext_mode = m; hpos = p;
    if (we) begin
      if (a == 2'd0) m_open = d;
      else if (a == 2'd1) m_close = d;
      else if (a == 2'd2 && m) m_ext = d;
    end
    so = {m & m_ext[5],  m_open[7:0]};
    sc = {m & m_ext[13], m_close[7:0]};
    #1 check(win_en, m_en, "R9");
    if (fires(sc, p)) m_en = 1'b0;
    else if (fires(so, p)) m_en = 1'b1;
    @(posedge clk); #1;
    check(win_en, m_en, tag);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sweep(input logic m, input string tag);
    for (int p = 0; p < 512; p++) tick(1'b0, 2'd3, 16'h0, m, 9'(p), tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic m,
                    input string tag);
    tick(1'b1, a, d, m, 9'h1FF, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); #1;
    check(win_en, 1'b0, "R1");
    m_open = '0; m_close = '0; m_ext = '0; m_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    sweep(1'b1, "R1");
    sweep(1'b0, "R1");

    // Legacy window
    wr(2'd0, 16'hAB30, 1'b0, "R8");
    wr(2'd1, 16'hCD90, 1'b0, "R8");
    sweep(1'b0, "R8");

    // Extended mode, ninth bit set on both edges
    wr(2'd2, 16'h2020, 1'b1, "R2");
    wr(2'd0, 16'h0010, 1'b1, "R2");
    wr(2'd1, 16'h0040, 1'b1, "R3");
    sweep(1'b1, "R2");
    wr(2'd2, 16'h2000, 1'b1, "R3");
    sweep(1'b1, "R3");
    wr(2'd2, 16'h0020, 1'b1, "R2");
    wr(2'd1, 16'h00F0, 1'b1, "R3");
    sweep(1'b1, "R3");

    // Unreachable positions
    wr(2'd2, 16'h2020, 1'b1, "R4");
    wr(2'd0, 16'h00C8, 1'b1, "R4");
    wr(2'd1, 16'h0005, 1'b1, "R4");
    sweep(1'b1, "R4");
    wr(2'd0, 16'h0008, 1'b1, "R4");
    wr(2'd1, 16'h00FF, 1'b1, "R4");
    sweep(1'b1, "R4");
    sweep(1'b1, "R4");

    // Reserved positions 0 and 1
    do_reset();
    wr(2'd0, 16'h0001, 1'b0, "R5");
    wr(2'd1, 16'h0000, 1'b0, "R5");
    sweep(1'b0, "R5");
    wr(2'd0, 16'h0020, 1'b0, "R5");
    wr(2'd1, 16'h0001, 1'b0, "R5");
    sweep(1'b0, "R5");
    sweep(1'b0, "R5");

    // Legacy ignores extension register
    do_reset();
    wr(2'd2, 16'hFFFF, 1'b0, "R6");
    wr(2'd0, 16'h0040, 1'b0, "R6");
    wr(2'd1, 16'h0060, 1'b0, "R6");
    sweep(1'b1, "R6");
    wr(2'd2, 16'h2020, 1'b1, "R6");
    sweep(1'b0, "R6");
    sweep(1'b1, "R6");

    // Equal positions: close wins
    do_reset();
    wr(2'd0, 16'h0050, 1'b0, "R8");
    wr(2'd1, 16'h0050, 1'b0, "R8");
    sweep(1'b0, "R8");
    wr(2'd1, 16'h0070, 1'b0, "R8");
    sweep(1'b0, "R8");

    // Same-edge writes, mid-line moves, ignored address
    do_reset();
    wr(2'd1, 16'h0090, 1'b0, "R7");
    tick(1'b0, 2'd3, 16'h0, 1'b0, 9'h4F, "R7");
    tick(1'b1, 2'd0, 16'h0050, 1'b0, 9'h50, "R7");
    tick(1'b0, 2'd3, 16'h0, 1'b0, 9'h51, "R7");
    tick(1'b1, 2'd1, 16'h0052, 1'b0, 9'h52, "R7");
    tick(1'b1, 2'd0, 16'h0053, 1'b0, 9'h53, "R7");
    tick(1'b1, 2'd3, 16'h0054, 1'b0, 9'h54, "R7");
    tick(1'b0, 2'd3, 16'h0, 1'b0, 9'h55, "R7");
    tick(1'b1, 2'd2, 16'h2000, 1'b1, 9'h56, "R7");
    tick(1'b1, 2'd1, 16'h0057, 1'b1, 9'h157, "R7");
    tick(1'b0, 2'd3, 16'h0, 1'b1, 9'h158, "R7");
    sweep(1'b1, "R7");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: expected completion, got hang");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule